// File: doc/BRIEF.md
# Relay Leg Sequencer for Iterative Syndrome Decoding

This block drives a chain of restarted belief-propagation runs ("legs") around an external decoding core. The core does the message passing and tests whether its current hard decision satisfies the syndrome. The sequencer runs the core's two phases in turn: a check phase, then a variable phase. It counts the iterations inside each leg and counts the legs. After every variable phase it reads the core's convergence flag.

Each leg that converges supplies a candidate correction and its cost. The cost is an unsigned number from outside: the sum of the prior weights of the error bits that the candidate flips. The sequencer keeps the cheapest candidate. It stops when it has collected a programmed number of solutions or when the last leg ends. It then raises done, reports the kept correction, and raises success if any leg converged.

The core's memory term is cleared only when a new decode starts. It is never cleared at a leg boundary, so each leg begins from the belief state the previous leg left behind. The three limits (iterations per leg, leg count and solution target) must be held steady while a decode is running.

Top module: `relay_leg_ctrl`

## Requirements
- R1: A start pulse starts a decode on the next cycle. In that cycle busy is high, done is low, the solution count is 0, the best cost is all ones, the leg index and iteration index are 0, and leg_start and mem_clear are both high.
- R2: While busy, core_phase alternates between 0 (check) and 1 (variable), beginning with 0. The iteration index goes up by one after each cycle in which core_phase is 1, so one iteration takes two cycles.
- R3: A leg that does not converge ends after max_iter iterations. The next leg then begins on the following cycle: the leg index goes up by one, the iteration index returns to 0, and leg_start is high for that one cycle.
- R4: When sat is high in a variable-phase cycle, the current leg ends at once. The solution count goes up by one, and the next leg (if any) begins on the following cycle.
- R5: When the solution count reaches target_sols, the decode finishes with done and success high.
- R6: The best cost and the correction take a candidate's cost and hard decision only when its cost is strictly below the best held so far. The first candidate of a decode is always taken. On a tie the earlier candidate stays.
- R7: If the last leg ends and no leg has converged, done goes high with success low. The correction is then the hard decision from the final variable phase, and the best cost stays all ones.
- R8: If the last leg ends and at least one leg converged, done and success go high and the correction is the cheapest candidate.
- R9: mem_clear is high only in the cycle after a start pulse. Leg boundaries never raise it.
- R10: done stays high and the outputs stay unchanged until the next start. A start during a decode abandons that decode and begins a new one.
- R11: A value of 0 for max_iter, max_legs or target_sols acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a new decode |
| max_iter | input | ITER_W | Iteration limit for each leg |
| max_legs | input | LEG_W | Number of legs in the relay |
| target_sols | input | SOL_W | Solution count at which the decode ends early |
| sat | input | 1 | Core hard decision satisfies the syndrome (read when core_phase is 1) |
| hard_dec | input | BITS | Core's current hard decision |
| cand_cost | input | COST_W | Cost of the current hard decision |
| core_phase | output | 1 | 0 = check phase, 1 = variable phase |
| leg_start | output | 1 | High in the first cycle of every leg |
| mem_clear | output | 1 | Clears the core memory term at the start of a decode |
| leg_idx | output | LEG_W | Current leg |
| iter_idx | output | ITER_W | Iteration within the current leg |
| busy | output | 1 | A decode is running |
| done | output | 1 | The decode has finished |
| success | output | 1 | At least one solution was found |
| correction | output | BITS | The reported correction |
| best_cost | output | COST_W | Cost of the kept candidate |
| sol_count | output | SOL_W | Number of solutions found in this decode |

## Verification
Within one variable-phase cycle, three events can coincide: a convergence, the leg's own iteration cap, and the relay's last leg. Any of them may also coincide with the solution target being reached. The stimulus table places the core's success on the cap iteration of a leg, and on the final iteration of the final leg with a cheaper cost. Each such case is judged by the reported success and correction and by the exact number of busy cycles, since a wrong order of resolution shifts the cycle count or keeps the wrong candidate. A second start in mid-decode checks that a restart wins over the running leg.

// File: rtl/relay_leg_ctrl.sv
module relay_leg_ctrl #(
  parameter int BITS   = 16,
  parameter int COST_W = 8,
  parameter int ITER_W = 6,
  parameter int LEG_W  = 3,
  parameter int SOL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ITER_W-1:0] max_iter,
  input  logic [LEG_W-1:0]  max_legs,
  input  logic [SOL_W-1:0]  target_sols,
  input  logic              sat,
  input  logic [BITS-1:0]   hard_dec,
  input  logic [COST_W-1:0] cand_cost,
  output logic              core_phase,
  output logic              leg_start,
  output logic              mem_clear,
  output logic [LEG_W-1:0]  leg_idx,
  output logic [ITER_W-1:0] iter_idx,
  output logic              busy,
  output logic              done,
  output logic              success,
  output logic [BITS-1:0]   correction,
  output logic [COST_W-1:0] best_cost,
  output logic [SOL_W-1:0]  sol_count
);

  localparam logic [ITER_W:0]   ITER_ONE = (ITER_W+1)'(1);
  localparam logic [LEG_W:0]    LEG_ONE  = (LEG_W+1)'(1);
  localparam logic [SOL_W:0]    SOL_ONE  = (SOL_W+1)'(1);
  localparam logic [COST_W-1:0] COST_MAX = '1;

  logic              busy_q, done_q, ok_q, phase_q, have_q, ls_q, mc_q;
  logic [ITER_W-1:0] iter_q;
  logic [LEG_W-1:0]  leg_q;
  logic [SOL_W-1:0]  sols_q;
  logic [COST_W-1:0] best_q;
  logic [BITS-1:0]   corr_q;

  logic [ITER_W:0] iter_lim, iter_nx;
  logic [LEG_W:0]  leg_lim, leg_nx;
  logic [SOL_W:0]  sol_lim, sols_nx;
  logic            iter_end, found, take, iter_last, leg_over, last_leg, target_hit, finish;

  assign iter_lim = (max_iter == '0)    ? ITER_ONE : {1'b0, max_iter};
  assign leg_lim  = (max_legs == '0)    ? LEG_ONE  : {1'b0, max_legs};
  assign sol_lim  = (target_sols == '0) ? SOL_ONE  : {1'b0, target_sols};

  assign iter_nx  = {1'b0, iter_q} + ITER_ONE;
  assign leg_nx   = {1'b0, leg_q} + LEG_ONE;
  assign sols_nx  = {1'b0, sols_q} + SOL_ONE;

  assign iter_end   = busy_q && phase_q;
  assign found      = iter_end && sat;
  assign take       = found && (!have_q || (cand_cost < best_q));
  assign iter_last  = iter_nx >= iter_lim;
  assign leg_over   = iter_end && (found || iter_last);
  assign last_leg   = leg_nx >= leg_lim;
  assign target_hit = found && (sols_nx >= sol_lim);
  assign finish     = target_hit || (leg_over && last_leg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      phase_q <= 1'b0;
      have_q  <= 1'b0;
      ls_q    <= 1'b0;
      mc_q    <= 1'b0;
      iter_q  <= '0;
      leg_q   <= '0;
      sols_q  <= '0;
      best_q  <= COST_MAX;
      corr_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      phase_q <= 1'b0;
      have_q  <= 1'b0;
      ls_q    <= 1'b1;
      mc_q    <= 1'b1;
      iter_q  <= '0;
      leg_q   <= '0;
      sols_q  <= '0;
      best_q  <= COST_MAX;
    end else begin
      ls_q <= 1'b0;
      mc_q <= 1'b0;
      if (busy_q) begin
        phase_q <= ~phase_q;
        if (iter_end) begin
          if (take) begin
            best_q <= cand_cost;
            corr_q <= hard_dec;
            have_q <= 1'b1;
          end
          if (found)
            sols_q <= sols_nx[SOL_W-1:0];
          if (finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            ok_q   <= have_q || found;
            if (!(have_q || found))
              corr_q <= hard_dec;
          end else if (leg_over) begin
            leg_q  <= leg_nx[LEG_W-1:0];
            iter_q <= '0;
            ls_q   <= 1'b1;
          end else begin
            iter_q <= iter_nx[ITER_W-1:0];
          end
        end
      end
    end
  end

  assign core_phase = phase_q;
  assign leg_start  = ls_q;
  assign mem_clear  = mc_q;
  assign leg_idx    = leg_q;
  assign iter_idx   = iter_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign success    = ok_q;
  assign correction = corr_q;
  assign best_cost  = best_q;
  assign sol_count  = sols_q;

endmodule

// File: rtl/relay_leg_ctrl_chk.sv
module relay_leg_ctrl_chk #(
  parameter int BITS   = 16,
  parameter int COST_W = 8,
  parameter int ITER_W = 6,
  parameter int LEG_W  = 3,
  parameter int SOL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ITER_W-1:0] max_iter,
  input logic [SOL_W-1:0]  target_sols,
  input logic              core_phase,
  input logic              leg_start,
  input logic              mem_clear,
  input logic [ITER_W-1:0] iter_idx,
  input logic              busy,
  input logic              done,
  input logic [BITS-1:0]   correction,
  input logic [COST_W-1:0] best_cost,
  input logic [SOL_W-1:0]  sol_count
);

  a_r2_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_phase && !start) |=> core_phase);

  a_r3_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |-> (iter_idx == '0 || iter_idx < max_iter));

  a_r3_leg_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    leg_start |-> (busy && !core_phase && iter_idx == '0));

  a_r5_sol_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |-> (sol_count < target_sols || sol_count == '0));

  a_r6_cost_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (best_cost <= $past(best_cost)));

  a_r9_clear_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear |-> $past(start));

  a_r10_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(correction) && $stable(best_cost)));

endmodule

bind relay_leg_ctrl relay_leg_ctrl_chk #(
  .BITS(BITS), .COST_W(COST_W), .ITER_W(ITER_W), .LEG_W(LEG_W), .SOL_W(SOL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .max_iter(max_iter),
  .target_sols(target_sols), .core_phase(core_phase), .leg_start(leg_start),
  .mem_clear(mem_clear), .iter_idx(iter_idx), .busy(busy), .done(done),
  .correction(correction), .best_cost(best_cost), .sol_count(sol_count)
);

// File: tb/relay_leg_ctrl_test.sv
module relay_leg_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] max_iter = '0;
  logic [2:0] max_legs = '0;
  logic [2:0] target_sols = '0;
  logic sat;
  logic [15:0] hard_dec;
  logic [7:0] cand_cost;
  logic core_phase, leg_start, mem_clear, busy, done, success;
  logic [2:0] leg_idx, sol_count;
  logic [5:0] iter_idx;
  logic [15:0] correction;
  logic [7:0] best_cost;

  logic [15:0] cur_ci = 16'hFFFF;
  logic [31:0] cur_co = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  relay_leg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_iter(max_iter),
    .max_legs(max_legs), .target_sols(target_sols), .sat(sat),
    .hard_dec(hard_dec), .cand_cost(cand_cost), .core_phase(core_phase),
    .leg_start(leg_start), .mem_clear(mem_clear), .leg_idx(leg_idx),
    .iter_idx(iter_idx), .busy(busy), .done(done), .success(success),
    .correction(correction), .best_cost(best_cost), .sol_count(sol_count)
  );

  // core model: leg L converges at iteration ci[L]; decision = {leg, iter, cost}
  assign cand_cost = cur_co[leg_idx[1:0]*8 +: 8];
  assign sat       = core_phase && (cur_ci[leg_idx[1:0]*4 +: 4] == iter_idx[3:0]);
  assign hard_dec  = {1'b0, leg_idx, iter_idx[3:0], cand_cost};

  typedef struct packed {
    logic [5:0]  mi;
    logic [2:0]  ml;
    logic [2:0]  tg;
    logic [15:0] ci;
    logic [31:0] co;
    logic        ok;
    logic [7:0]  ecost;
    logic [2:0]  esols;
    logic [15:0] ecorr;
    logic [7:0]  ebusy;
    logic [2:0]  elegs;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{6'd4, 3'd3, 3'd1, 16'hFF2F, 32'h0014370A, 1'b1, 8'h37, 3'd1, 16'h1237, 8'd14, 3'd2},
    '{6'd4, 3'd3, 3'd2, 16'hF301, 32'h00503040, 1'b1, 8'h30, 3'd2, 16'h1030, 8'd6,  3'd2},
    '{6'd3, 3'd3, 3'd3, 16'hF210, 32'h00502020, 1'b1, 8'h20, 3'd3, 16'h0020, 8'd12, 3'd3},
    '{6'd2, 3'd3, 3'd1, 16'hFFFF, 32'h00330201, 1'b0, 8'hFF, 3'd0, 16'h2133, 8'd12, 3'd3},
    '{6'd3, 3'd2, 3'd2, 16'hFF1F, 32'h00004405, 1'b1, 8'h44, 3'd1, 16'h1144, 8'd10, 3'd2},
    '{6'd2, 3'd2, 3'd1, 16'hFFF1, 32'h00000066, 1'b1, 8'h66, 3'd1, 16'h0166, 8'd4,  3'd1},
    '{6'd0, 3'd0, 3'd0, 16'hFFFF, 32'h00000077, 1'b0, 8'hFF, 3'd0, 16'h0077, 8'd2,  3'd1},
    '{6'd2, 3'd4, 3'd4, 16'h1FF0, 32'h12000090, 1'b1, 8'h12, 3'd2, 16'h3112, 8'd14, 3'd4}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_and_start(input vec_t v);
    @(negedge clk);
    max_iter = v.mi; max_legs = v.ml; target_sols = v.tg;
    cur_ci = v.ci; cur_co = v.co;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_to_done(output int nb, output int nls, output int nmc);
    int guard;
    nb = 0; nls = 0; nmc = 0; guard = 0;
    while (!done && guard < 2000) begin
      if (busy) nb++;
      if (leg_start) nls++;
      if (mem_clear) nmc++;
      @(negedge clk);
      guard++;
    end
    if (!done) check("R10", "decode never finished", 0, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int nb, nls, nmc;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset busy", busy, 0);
    check("R1", "reset done", done, 0);
    check("R1", "reset success", success, 0);
    check("R1", "reset phase", core_phase, 0);
    check("R1", "reset sol_count", sol_count, 0);
    rst_n = 1'b1;

    // table walk: R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      load_and_start(VECS[i]);
      run_to_done(nb, nls, nmc);
      check("R5/R7/R8", $sformatf("v%0d success", i), success, VECS[i].ok);
      check("R6", $sformatf("v%0d best_cost", i), best_cost, VECS[i].ecost);
      check("R4", $sformatf("v%0d sol_count", i), sol_count, VECS[i].esols);
      check("R6/R7", $sformatf("v%0d correction", i), correction, VECS[i].ecorr);
      check("R2/R3/R11", $sformatf("v%0d busy cycles", i), nb, VECS[i].ebusy);
      check("R3", $sformatf("v%0d leg_start pulses", i), nls, VECS[i].elegs);
      check("R9", $sformatf("v%0d mem_clear pulses", i), nmc, 1);
    end

    // R10: done and outputs hold
    held = correction;
    repeat (5) @(negedge clk);
    check("R10", "done held", done, 1);
    check("R10", "correction held", correction, held);

    // R1 and R2: start after a finished decode clears state; phase sequence
    load_and_start(VECS[3]);
    check("R1", "busy after start", busy, 1);
    check("R1", "done cleared", done, 0);
    check("R1", "best_cost all ones", best_cost, 8'hFF);
    check("R1", "sol_count cleared", sol_count, 0);
    check("R1", "leg_idx cleared", leg_idx, 0);
    check("R1", "iter_idx cleared", iter_idx, 0);
    check("R1", "leg_start first cycle", leg_start, 1);
    check("R1", "mem_clear first cycle", mem_clear, 1);
    check("R2", "check phase first", core_phase, 0);
    @(negedge clk);
    check("R2", "variable phase second", core_phase, 1);
    check("R2", "iter before advance", iter_idx, 0);
    check("R9", "mem_clear one cycle", mem_clear, 0);
    @(negedge clk);
    check("R2", "iter advanced", iter_idx, 1);
    check("R2", "back to check phase", core_phase, 0);
    @(negedge clk);
    @(negedge clk);
    check("R3", "next leg after cap", leg_idx, 1);
    check("R3", "iter reset at leg", iter_idx, 0);
    check("R3", "leg_start at new leg", leg_start, 1);
    check("R9", "no mem_clear at leg boundary", mem_clear, 0);

    // R10: restart mid-decode
    load_and_start(VECS[5]);
    check("R10", "restart leg_idx", leg_idx, 0);
    check("R10", "restart iter_idx", iter_idx, 0);
    run_to_done(nb, nls, nmc);
    check("R10", "restart success", success, 1);
    check("R10", "restart correction", correction, 16'h0166);
    check("R10", "restart busy cycles", nb, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule